// File: doc/BRIEF.md
# Shadow Memory Routing Decoder

This block decides, for each memory access, whether internal DRAM serves it or whether it goes out to the external bus. The upper 256 KB below 1 MB (0xC0000 to 0xFFFFF) is cut into sixteen 16 KB segments. Each segment has its own read-shadow bit and its own write-shadow bit, so a ROM image can be read from the bus while writes land in DRAM, or the reverse. A separate hole-control byte governs the video window, the 0x80000 window and two 1 MB windows just under 16 MB. The polarity of that byte's bits is not uniform: one bit pulls its window into DRAM, while the others push their windows out to the bus.

Accesses arrive as a single-cycle `acc_valid` pulse with an address and a write flag. The verdict comes back one clock later on `rt_valid`/`rt_internal`. The block never stalls: it has no ready signal, and it accepts an access on every cycle. Configuration is written one byte at a time through `cfg_we`/`cfg_sel`/`cfg_wdata`. Two level outputs report whether any segment from 0xE0000 upward is shadowed for reads or for writes.

Top module: `shadow_route_top`

## Requirements
- R1: After reset every read-shadow bit, write-shadow bit and hole bit is zero. Both BIOS flags are 0, the segment area and 0xA0000–0xBFFFF route external, and 0x80000–0x9FFFF routes internal.
- R2: A read of segment i (address 0xC0000 + i×0x4000 up to that plus 0x3FFF) routes internal exactly when read-shadow bit i is 1. Bits 0–7 come from `cfg_sel`=0 and bits 8–15 from `cfg_sel`=1, where data bit k holds segment k or k+8.
- R3: A write to segment i routes internal exactly when write-shadow bit i is 1. These bits come from `cfg_sel`=2 (segments 0–7) and `cfg_sel`=3 (segments 8–15), and they are independent of the read bits.
- R4: `bios_rd_shadow` is the OR of read-shadow bits 8–15 and `bios_wr_shadow` is the OR of write-shadow bits 8–15. Both change in the cycle after the configuration write and hold otherwise.
- R5: The hole byte is written with `cfg_sel`=4. When its bit 3 is 1, 0xA0000–0xBFFFF routes internal; when bit 3 is 0, that window routes external.
- R6: When hole bit 2 is 1, 0x80000–0x9FFFF routes external; otherwise it routes internal.
- R7: When hole bit 5 is 1 and `mem_mb` > 14, 0xE00000–0xEFFFFF routes external. When hole bit 4 is 1 and `mem_mb` > 15, 0xF00000–0xFFFFFF routes external. Otherwise both windows route internal.
- R8: Every other address routes internal. Hole bits 0, 1, 6 and 7 are discarded and have no effect on any routing.
- R9: When `acc_valid` is sampled high at a clock edge, `rt_valid` is 1 and `rt_internal` holds the verdict after that edge. At all other times both are 0. A configuration write takes effect for an access presented in the next cycle.
- R10: A configuration write with `cfg_sel` 5, 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 3 | Register select: 0/1 read shadow, 2/3 write shadow, 4 hole byte |
| cfg_wdata | input | 8 | Configuration byte |
| mem_mb | input | 8 | Installed memory size in MB |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 32 | Access byte address |
| rt_valid | output | 1 | Verdict present (one cycle after the access) |
| rt_internal | output | 1 | 1 = internal DRAM, 0 = external bus |
| bios_rd_shadow | output | 1 | Some segment at or above 0xE0000 is read-shadowed |
| bios_wr_shadow | output | 1 | Some segment at or above 0xE0000 is write-shadowed |

## Verification
The routing verdict is due one edge after the edge that samples `acc_valid`. The bench therefore drives each access at a falling edge, waits for the next rising edge, and compares 2 ns later against a model evaluated on the configuration in force at drive time. The BIOS flags are due one edge after a configuration write. The bench updates its model at that same rising edge and compares both flags 2 ns after every rising edge. Idle cycles are checked for a cleared `rt_valid`.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;
  localparam int unsigned SEG_SHIFT = 14;
  localparam logic [31:0] SEG_BASE  = 32'h000C_0000;
  localparam logic [31:0] VGA_BASE  = 32'h000A_0000;
  localparam logic [31:0] LOW_BASE  = 32'h0008_0000;
  localparam logic [31:0] HIE_BASE  = 32'h00E0_0000;
  localparam logic [31:0] HIF_BASE  = 32'h00F0_0000;
  localparam logic [31:0] TOP_16M   = 32'h0100_0000;
  localparam logic [7:0]  HIE_MB    = 8'd14;
  localparam logic [7:0]  HIF_MB    = 8'd15;

  // field order mirrors data bits 5..2 of the hole byte
  typedef struct packed {
    logic hie_ext;
    logic hif_ext;
    logic vga_int;
    logic low_ext;
  } hole_cfg_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_route_pkg::*;
#(
  parameter int unsigned NUM_SEGS = 16,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [7:0]          cfg_wdata,
  output logic [NUM_SEGS-1:0] rd_en,
  output logic [NUM_SEGS-1:0] wr_en,
  output hole_cfg_t           hole
);
  localparam int unsigned NBYTES = NUM_SEGS / 8;
  localparam int unsigned HOLE_SEL = 2 * NBYTES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en <= '0;
      wr_en <= '0;
      hole  <= '0;
    end else if (cfg_we) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (cfg_sel == SEL_W'(b))          rd_en[b*8 +: 8] <= cfg_wdata;
        if (cfg_sel == SEL_W'(NBYTES + b)) wr_en[b*8 +: 8] <= cfg_wdata;
      end
      if (cfg_sel == SEL_W'(HOLE_SEL)) hole <= hole_cfg_t'(cfg_wdata[5:2]);
    end
  end
endmodule

// File: rtl/shadow_seg_lookup.sv
module shadow_seg_lookup #(
  parameter int unsigned NUM_SEGS = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic [NUM_SEGS-1:0] rd_en,
  input  logic [NUM_SEGS-1:0] wr_en,
  input  logic [IDX_W-1:0]    seg_idx,
  input  logic                is_write,
  output logic                seg_int,
  output logic                bios_rd,
  output logic                bios_wr
);
  localparam int unsigned HALF = NUM_SEGS / 2;

  logic [NUM_SEGS-1:0] pick;
  genvar g;
  generate
    for (g = 0; g < NUM_SEGS; g++) begin : g_pick
      assign pick[g] = is_write ? wr_en[g] : rd_en[g];
    end
  endgenerate

  assign seg_int = pick[seg_idx];
  assign bios_rd = |rd_en[NUM_SEGS-1:HALF];
  assign bios_wr = |wr_en[NUM_SEGS-1:HALF];
endmodule

// File: rtl/shadow_region_dec.sv
module shadow_region_dec
  import shadow_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_SEGS = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        mem_mb,
  input  hole_cfg_t         hole,
  input  logic              seg_int,
  output logic [IDX_W-1:0]  seg_idx,
  output logic              internal
);
  localparam logic [ADDR_W-1:0] A_SEG = ADDR_W'(SEG_BASE);
  localparam logic [ADDR_W-1:0] A_SEND =
    ADDR_W'(SEG_BASE + (NUM_SEGS << SEG_SHIFT));
  localparam logic [ADDR_W-1:0] A_VGA = ADDR_W'(VGA_BASE);
  localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(LOW_BASE);
  localparam logic [ADDR_W-1:0] A_HIE = ADDR_W'(HIE_BASE);
  localparam logic [ADDR_W-1:0] A_HIF = ADDR_W'(HIF_BASE);
  localparam logic [ADDR_W-1:0] A_TOP = ADDR_W'(TOP_16M);

  logic [ADDR_W-1:0] seg_off;
  logic in_seg, in_vga, in_low, in_hie, in_hif;

  assign seg_off = addr - A_SEG;
  assign seg_idx = seg_off[SEG_SHIFT +: IDX_W];
  assign in_seg  = (addr >= A_SEG) && (addr < A_SEND);
  assign in_vga  = (addr >= A_VGA) && (addr < A_SEG);
  assign in_low  = (addr >= A_LOW) && (addr < A_VGA);
  assign in_hie  = (addr >= A_HIE) && (addr < A_HIF);
  assign in_hif  = (addr >= A_HIF) && (addr < A_TOP);

  always_comb begin
    internal = 1'b1;
    if (in_seg)      internal = seg_int;
    else if (in_vga) internal = hole.vga_int;
    else if (in_low) internal = !hole.low_ext;
    else if (in_hie) internal = !(hole.hie_ext && (mem_mb > HIE_MB));
    else if (in_hif) internal = !(hole.hif_ext && (mem_mb > HIF_MB));
  end
endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
  import shadow_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_SEGS = 16,
  parameter int unsigned SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic [7:0]        mem_mb,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rt_valid,
  output logic              rt_internal,
  output logic              bios_rd_shadow,
  output logic              bios_wr_shadow
);
  localparam int unsigned IDX_W = $clog2(NUM_SEGS);

  logic [NUM_SEGS-1:0] rd_en, wr_en;
  hole_cfg_t           hole_q;
  logic [IDX_W-1:0]    seg_idx;
  logic                seg_int, verdict;

  shadow_cfg_regs #(.NUM_SEGS(NUM_SEGS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_en(rd_en), .wr_en(wr_en), .hole(hole_q)
  );

  shadow_seg_lookup #(.NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_seg (
    .rd_en(rd_en), .wr_en(wr_en), .seg_idx(seg_idx), .is_write(acc_write),
    .seg_int(seg_int), .bios_rd(bios_rd_shadow), .bios_wr(bios_wr_shadow)
  );

  shadow_region_dec #(.ADDR_W(ADDR_W), .NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_dec (
    .addr(acc_addr), .mem_mb(mem_mb), .hole(hole_q), .seg_int(seg_int),
    .seg_idx(seg_idx), .internal(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rt_valid    <= 1'b0;
      rt_internal <= 1'b0;
    end else begin
      rt_valid    <= acc_valid;
      rt_internal <= acc_valid & verdict;
    end
  end
endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [3:0]        hole_bits,
  input logic              rt_valid,
  input logic              rt_internal,
  input logic              bios_rd_shadow,
  input logic              bios_wr_shadow
);
  a_r9_verdict_due: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rt_valid);
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!rt_valid && !rt_internal));
  a_r8_low_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr < ADDR_W'(32'h80000)) |=> rt_internal);
  a_r8_above_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr >= ADDR_W'(32'h1000000)) |=> rt_internal);
  a_r5_vga_window: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr >= ADDR_W'(32'hA0000) && acc_addr < ADDR_W'(32'hC0000))
      |=> (rt_internal == $past(hole_bits[1])));
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(bios_rd_shadow) && $stable(bios_wr_shadow)));
endmodule

bind shadow_route_top shadow_route_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .hole_bits(hole_q), .rt_valid(rt_valid),
  .rt_internal(rt_internal), .bios_rd_shadow(bios_rd_shadow),
  .bios_wr_shadow(bios_wr_shadow)
);

// File: tb/test_shadow_route_top.sv
`timescale 1ns/1ps
module test_shadow_route_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0, mem_mb = 8'd16;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic rt_valid, rt_internal, bios_rd_shadow, bios_wr_shadow;

  int n_chk = 0, n_fail = 0;
  bit [15:0] m_rd = '0, m_wr = '0;
  bit [7:0]  m_hole = '0;
  bit run_flags = 1'b0;

  always #4 clk = ~clk;

  shadow_route_top i_shadow_route_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_mb(mem_mb), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .rt_valid(rt_valid),
    .rt_internal(rt_internal), .bios_rd_shadow(bios_rd_shadow),
    .bios_wr_shadow(bios_wr_shadow)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_route(input bit [31:0] a, input bit wr);
    if (a >= 32'hC0000 && a < 32'h100000) begin
      int s = int'((a - 32'hC0000) / 32'h4000);
      return wr ? m_wr[s] : m_rd[s];
    end
    if (a >= 32'hA0000 && a < 32'hC0000) return m_hole[3];
    if (a >= 32'h80000 && a < 32'hA0000) return !m_hole[2];
    if (a >= 32'hE00000 && a < 32'hF00000) return !(m_hole[5] && mem_mb > 14);
    if (a >= 32'hF00000 && a < 32'h1000000) return !(m_hole[4] && mem_mb > 15);
    return 1'b1;
  endfunction

  // R4: flags compared against the model after every rising edge
  always @(posedge clk) begin
    #2;
    if (run_flags) begin
      chk("R4 rd flag", bios_rd_shadow, |m_rd[15:8]);
      chk("R4 wr flag", bios_wr_shadow, |m_wr[15:8]);
    end
  end

  task automatic cfg(input int sel, input bit [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = v;
    @(posedge clk);
    case (sel)
      0: m_rd[7:0]  = v;
      1: m_rd[15:8] = v;
      2: m_wr[7:0]  = v;
      3: m_wr[15:8] = v;
      4: m_hole     = v & 8'h3C;
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input string req, input bit [31:0] a, input bit wr);
    bit e;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    e = model_route(a, wr);
    @(posedge clk);
    #2;
    chk({req, " valid"}, rt_valid, 1'b1);
    chk({req, " route"}, rt_internal, e);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    run_flags = 1'b1;
    @(posedge clk); #2;
    // R1: reset state
    chk("R1 rd flag", bios_rd_shadow, 1'b0);
    chk("R1 wr flag", bios_wr_shadow, 1'b0);
    chk("R9 idle", rt_valid, 1'b0);
    access("R1 seg ext", 32'hC0000, 1'b0);
    access("R1 vga ext", 32'hA0000, 1'b0);
    access("R1 low int", 32'h80000, 1'b0);
    access("R1 hiE int", 32'hE00000, 1'b0);
    // R2: read shadow bits
    cfg(0, 8'h05);
    access("R2 seg0", 32'hC0000, 1'b0);
    access("R2 seg1", 32'hC4000, 1'b0);
    access("R2 seg2 end", 32'hCBFFF, 1'b0);
    access("R3 seg0 wr", 32'hC0000, 1'b1);
    cfg(1, 8'h80);
    access("R2 seg15", 32'hFC000, 1'b0);
    access("R2 seg14", 32'hF8000, 1'b0);
    // R3: write shadow bits independent of reads
    cfg(3, 8'h01);
    access("R3 seg8 wr", 32'hE0000, 1'b1);
    access("R3 seg8 rd", 32'hE0000, 1'b0);
    cfg(2, 8'h40);
    access("R3 seg6 wr", 32'hD8000, 1'b1);
    access("R3 seg6 top", 32'hDBFFF, 1'b1);
    access("R3 seg7 wr", 32'hDC000, 1'b1);
    // R4: clearing flags
    cfg(1, 8'h00);
    cfg(3, 8'h00);
    // R10: unused selects ignored
    cfg(5, 8'hFF);
    cfg(7, 8'hFF);
    access("R10 seg1 rd", 32'hC4000, 1'b0);
    access("R10 vga", 32'hA0000, 1'b0);
    access("R10 seg12 wr", 32'hF0000, 1'b1);
    // R5
    cfg(4, 8'h08);
    access("R5 vga lo", 32'hA0000, 1'b0);
    access("R5 vga hi", 32'hBFFFF, 1'b1);
    access("R5 low int", 32'h80000, 1'b0);
    // R6
    cfg(4, 8'h04);
    access("R6 low ext", 32'h9FFFF, 1'b0);
    access("R6 vga ext", 32'hA0000, 1'b0);
    access("R6 below int", 32'h7FFFF, 1'b0);
    // R7: high holes gated by memory size
    cfg(4, 8'h30);
    mem_mb = 8'd16;
    access("R7 E 16MB", 32'hE00000, 1'b0);
    access("R7 F 16MB", 32'hFFFFFF, 1'b1);
    mem_mb = 8'd15;
    access("R7 E 15MB", 32'hEFFFFF, 1'b0);
    access("R7 F 15MB", 32'hF00000, 1'b0);
    mem_mb = 8'd14;
    access("R7 E 14MB", 32'hE00000, 1'b0);
    access("R7 above", 32'h1000000, 1'b0);
    // R8: discarded bits, uncontrolled ranges
    mem_mb = 8'd32;
    cfg(4, 8'hC3);
    access("R8 vga", 32'hA0000, 1'b0);
    access("R8 low", 32'h80000, 1'b1);
    access("R8 hiE", 32'hE00000, 1'b0);
    access("R8 1MB", 32'h100000, 1'b0);
    access("R8 base", 32'h50000, 1'b1);
    // R9: back-to-back, then idle
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'hC0000; acc_write = 1'b0;
    @(negedge clk);
    acc_addr = 32'hC4000;
    chk("R9 b2b first", rt_internal, model_route(32'hC0000, 1'b0));
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R9 b2b second", rt_internal, model_route(32'hC4000, 1'b0));
    chk("R9 b2b valid", rt_valid, 1'b1);
    @(posedge clk); #2;
    chk("R9 idle after", rt_valid, 1'b0);
    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule